// File: doc/BRIEF.md
# Cartridge Bank-Select Latch

This block is a write-only bank register for a retro console cartridge, built the way a discrete counter chip would be used as a latch. It watches the CPU bus: the M2 phase clock, address bit A15, the read/write strobe and the eight data lines. It combines M2 and A15 into an active-low ROM select. The select is low only while M2 is high and the CPU is addressing the upper half of memory.

The bank byte is not loaded on an ordinary clock edge. It is loaded on the trailing edge of the select, when the select goes from low back to high, and only if the cycle that just ended was a write. The CPU guarantees valid write data only at the end of the M2-high phase. Taking the data at the trailing edge therefore picks up the settled value and never a value from early in the phase.

The logic runs on a fast system clock. The bus pins are brought into that clock domain and the select edge is found there. Each bus sample taken while the select is low overwrites the held data and strobe. The sample still held when the select rises is the one that gets loaded. The low bits of the register drive the upper address lines of the cartridge memory.

Top module: `cart_bank_latch`

## Requirements
- R1: A synchronous active-high reset clears the bank register to 0, so `bank_o` reads 0. It also drives `rom_sel_n_o` high.
- R2: `rom_sel_n_o` is low exactly when both M2 and A15 are high. It follows the pins after a fixed synchroniser delay of SYNC_STAGES system clocks (default 2).
- R3: A write cycle (R/W low) with A15 high loads the data byte into the bank register. The new value appears on `bank_o` within 4 system clocks after M2 falls.
- R4: While M2 is still high in a write cycle, the bank output keeps its old value, even though the new data is already on the bus. The load happens only at the trailing select edge.
- R5: Read cycles (R/W high) to the upper half of memory toggle the select but leave the bank unchanged.
- R6: A write cycle with A15 low never pulls the select low and leaves the bank unchanged.
- R7: The loaded byte is the bus value at the end of the M2-high phase. If the data changes partway through the high phase, the later value wins. Data or strobe changes that arrive together with the M2 fall are not captured.
- R8: `bank_o` carries bits [BANK_BITS-1:0] of the 8-bit register (default BANK_BITS = 4). For example, a written 0xA7 shows as 4'h7.
- R9: In a four-cycle absolute store to the upper half of memory (three reads, then one write), the bank does not change after any of the three reads. It takes the written value only after the fourth cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast system clock |
| rst | input | 1 | Synchronous active-high reset |
| m2_i | input | 1 | CPU M2 phase clock pin |
| a15_i | input | 1 | CPU address bit 15 |
| rw_i | input | 1 | CPU read/write strobe, low means write |
| data_i | input | 8 | CPU data bus |
| rom_sel_n_o | output | 1 | Synchronised active-low ROM select, NAND of M2 and A15 |
| bank_o | output | BANK_BITS | Low bits of the latched bank number |

## Verification
The bank is driven with complete bus cycles of four kinds: writes to the upper half, reads to the upper half, writes to the lower half, and a full three-read-plus-write store sequence. Comparing these shows that only the combination of select activity and a low strobe loads the register. Some write cycles put one byte on the bus early in the M2-high phase and a different byte late in it. Others swap the data and strobe at the moment M2 falls. Together these show that the byte taken is the settled end-of-phase value. A bank check in the middle of every high phase shows that nothing is loaded before the trailing select edge.

// File: rtl/cart_latch_pkg.sv
package cart_latch_pkg;

    localparam int BUS_DATA_W = 8;

    // One snapshot of the CPU-side pins.
    typedef struct packed {
        logic                  m2;
        logic                  a15;
        logic                  rw;
        logic [BUS_DATA_W-1:0] data;
    } bus_sample_t;

    // Value held from the most recent sample taken while the select was low.
    typedef struct packed {
        logic                  rw;
        logic [BUS_DATA_W-1:0] data;
    } capture_t;

    // Bus state during reset and idle: M2 low, lower half, reading.
    localparam bus_sample_t BUS_IDLE = '{m2: 1'b0, a15: 1'b0, rw: 1'b1, data: '0};
    localparam capture_t    CAP_IDLE = '{rw: 1'b1, data: '0};

    // Active-low ROM select formed from the phase clock and the top address bit.
    function automatic logic rom_select_n(input bus_sample_t s);
        return !(s.m2 && s.a15);
    endfunction

endpackage

// File: rtl/cart_bus_sync.sv
module cart_bus_sync
    import cart_latch_pkg::*;
#(
    parameter int STAGES = 2
) (
    input  logic        clk,
    input  logic        rst,
    input  bus_sample_t raw_i,
    output bus_sample_t sync_o
);

    bus_sample_t stage_q [STAGES];

    generate
        for (genvar g = 0; g < STAGES; g++) begin : g_stage
            if (g == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) stage_q[g] <= BUS_IDLE;
                    else     stage_q[g] <= raw_i;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (rst) stage_q[g] <= BUS_IDLE;
                    else     stage_q[g] <= stage_q[g-1];
                end
            end
        end
    endgenerate

    assign sync_o = stage_q[STAGES-1];

endmodule

// File: rtl/cart_sel_edge.sv
module cart_sel_edge
    import cart_latch_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  bus_sample_t           bus_i,
    output logic                  sel_n_o,
    output logic                  load_o,
    output logic [BUS_DATA_W-1:0] load_data_o
);

    logic     sel_n;
    logic     sel_n_q;
    logic     sel_rise;
    capture_t hold_q;

    always_comb begin
        sel_n    = rom_select_n(bus_i);
        sel_rise = sel_n && !sel_n_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sel_n_q <= 1'b1;
            hold_q  <= CAP_IDLE;
        end else begin
            sel_n_q <= sel_n;
            if (!sel_n) begin
                hold_q.rw   <= bus_i.rw;
                hold_q.data <= bus_i.data;
            end
        end
    end

    assign sel_n_o     = sel_n;
    assign load_o      = sel_rise && !hold_q.rw;
    assign load_data_o = hold_q.data;

    // R7: the held sample is frozen once the select is high
    a_r7_hold_frozen: assert property (@(posedge clk) disable iff (rst)
        sel_n |=> $stable(hold_q));

    // R3: a load is a single-cycle pulse per select edge
    a_r3_single_pulse: assert property (@(posedge clk) disable iff (rst)
        load_o |=> !load_o);

endmodule

// File: rtl/cart_bank_reg.sv
module cart_bank_reg
    import cart_latch_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  load_i,
    input  logic [BUS_DATA_W-1:0] data_i,
    output logic [BUS_DATA_W-1:0] bank_o
);

    logic [BUS_DATA_W-1:0] bank_q;

    always_ff @(posedge clk) begin
        if (rst)         bank_q <= '0;
        else if (load_i) bank_q <= data_i;
    end

    assign bank_o = bank_q;

    // R1: reset clears the register
    a_r1_reset_clear: assert property (@(posedge clk)
        rst |=> (bank_q == '0));

    // R5: without a load the register holds its value
    a_r5_hold_without_load: assert property (@(posedge clk) disable iff (rst)
        !load_i |=> $stable(bank_q));

endmodule

// File: rtl/cart_bank_latch.sv
module cart_bank_latch
    import cart_latch_pkg::*;
#(
    parameter int BANK_BITS   = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 m2_i,
    input  logic                 a15_i,
    input  logic                 rw_i,
    input  logic [7:0]           data_i,
    output logic                 rom_sel_n_o,
    output logic [BANK_BITS-1:0] bank_o
);

    localparam int OUT_BITS = (BANK_BITS < BUS_DATA_W) ? BANK_BITS : BUS_DATA_W;

    bus_sample_t           raw_bus;
    bus_sample_t           sync_bus;
    logic                  load;
    logic [BUS_DATA_W-1:0] load_data;
    logic [BUS_DATA_W-1:0] bank_full;

    assign raw_bus = '{m2: m2_i, a15: a15_i, rw: rw_i, data: data_i};

    cart_bus_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk    (clk),
        .rst    (rst),
        .raw_i  (raw_bus),
        .sync_o (sync_bus)
    );

    cart_sel_edge u_edge (
        .clk         (clk),
        .rst         (rst),
        .bus_i       (sync_bus),
        .sel_n_o     (rom_sel_n_o),
        .load_o      (load),
        .load_data_o (load_data)
    );

    cart_bank_reg u_bank (
        .clk    (clk),
        .rst    (rst),
        .load_i (load),
        .data_i (load_data),
        .bank_o (bank_full)
    );

    generate
        if (BANK_BITS > OUT_BITS) begin : g_pad
            assign bank_o = {{(BANK_BITS-OUT_BITS){1'b0}}, bank_full[OUT_BITS-1:0]};
        end else begin : g_slice
            assign bank_o = bank_full[OUT_BITS-1:0];
        end
    endgenerate

    // R2: select low only while synchronised M2 and A15 are both high
    a_r2_select_needs_both: assert property (@(posedge clk) disable iff (rst)
        !rom_sel_n_o |-> (sync_bus.m2 && sync_bus.a15));

    // R6: with A15 low in the synchronised bus, no load can be issued
    a_r6_lower_half_no_load: assert property (@(posedge clk) disable iff (rst)
        !sync_bus.a15 && $past(!sync_bus.a15) |-> !load);

endmodule

// File: tb/cart_bank_latch_tb.sv
module cart_bank_latch_tb;

    localparam int BANK_BITS = 4;

    logic                 clk = 1'b0;
    logic                 rst;
    logic                 m2, a15, rw;
    logic [7:0]           data;
    logic                 rom_sel_n;
    logic [BANK_BITS-1:0] bank;

    int         n_checks = 0;
    int         n_fail   = 0;
    logic [7:0] exp_bank = 8'h00;

    always #5 clk = ~clk;

    cart_bank_latch #(.BANK_BITS(BANK_BITS), .SYNC_STAGES(2)) u_dut (
        .clk         (clk),
        .rst         (rst),
        .m2_i        (m2),
        .a15_i       (a15),
        .rw_i        (rw),
        .data_i      (data),
        .rom_sel_n_o (rom_sel_n),
        .bank_o      (bank)
    );

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %02h expected %02h", req, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    function automatic logic [7:0] exp_out();
        return {4'h0, exp_bank[BANK_BITS-1:0]};
    endfunction

    // One CPU bus cycle; d_late is on the bus at the end of the M2-high phase.
    task automatic bus_cycle(input logic hi, input logic wr_n,
                             input logic [7:0] d_early, input logic [7:0] d_late,
                             input logic [7:0] d_after, input logic flip_rw);
        m2 = 1'b0; a15 = hi; rw = wr_n; data = d_early;
        tick(6);
        check("R2 select high while M2 low", {7'd0, rom_sel_n}, 8'h01);
        m2 = 1'b1;
        tick(4);
        data = d_late;
        tick(4);
        check("R2 select during M2 high", {7'd0, rom_sel_n}, {7'd0, !hi});
        check("R4 bank unchanged before trailing edge", {4'h0, bank}, exp_out());
        m2 = 1'b0; data = d_after;
        if (flip_rw) rw = ~wr_n;
        tick(2);
        a15 = 1'b0; rw = 1'b1;
        tick(4);
        if (hi && !wr_n) exp_bank = d_late;
    endtask

    task automatic t_reset();
        rst = 1'b1; m2 = 1'b0; a15 = 1'b0; rw = 1'b1; data = 8'h00;
        tick(4);
        check("R1 bank after reset", {4'h0, bank}, 8'h00);
        check("R1 select after reset", {7'd0, rom_sel_n}, 8'h01);
        rst = 1'b0;
        tick(2);
    endtask

    task automatic t_store_sequence();
        bus_cycle(1'b1, 1'b1, 8'h8D, 8'h8D, 8'h00, 1'b0);
        check("R9 bank after opcode read", {4'h0, bank}, exp_out());
        bus_cycle(1'b1, 1'b1, 8'h00, 8'h00, 8'h00, 1'b0);
        check("R9 bank after low operand read", {4'h0, bank}, exp_out());
        bus_cycle(1'b1, 1'b1, 8'h80, 8'h80, 8'h00, 1'b0);
        check("R9 bank after high operand read", {4'h0, bank}, exp_out());
        bus_cycle(1'b1, 1'b0, 8'hFF, 8'h03, 8'hFF, 1'b0);
        check("R9 R3 bank after write cycle", {4'h0, bank}, 8'h03);
    endtask

    task automatic t_reads_only();
        bus_cycle(1'b1, 1'b1, 8'h0C, 8'h0C, 8'h00, 1'b0);
        check("R5 read cycle leaves bank", {4'h0, bank}, exp_out());
        bus_cycle(1'b1, 1'b1, 8'h59, 8'h5E, 8'h00, 1'b0);
        check("R5 second read leaves bank", {4'h0, bank}, 8'h03);
    endtask

    task automatic t_lower_write();
        bus_cycle(1'b0, 1'b0, 8'h0A, 8'h0A, 8'h00, 1'b0);
        check("R6 lower-half write leaves bank", {4'h0, bank}, 8'h03);
    endtask

    task automatic t_late_data();
        bus_cycle(1'b1, 1'b0, 8'h01, 8'h0E, 8'h05, 1'b1);
        check("R7 late data wins over early and after-fall", {4'h0, bank}, 8'h0E);
        bus_cycle(1'b1, 1'b0, 8'h02, 8'hA7, 8'h0B, 1'b0);
        check("R8 R3 low bits of A7 on bank", {4'h0, bank}, 8'h07);
    endtask

    task automatic t_reset_again();
        rst = 1'b1;
        tick(2);
        check("R1 reset clears loaded bank", {4'h0, bank}, 8'h00);
        rst = 1'b0;
        exp_bank = 8'h00;
        tick(2);
    endtask

    initial begin
        t_reset();
        t_store_sequence();
        t_reads_only();
        t_lower_write();
        t_late_data();
        t_reset_again();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end

    initial begin
        #2_000_000;
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end

endmodule